// File: doc/BRIEF.md
# Sampling Converter Conversion and Serial Read Sequencer

This block sits on the host side of a 12-bit sampling converter that has a three-wire read path: a busy flag, a serial data line and a serial clock. When a start request arrives, it drives the active-low conversion-start line. It then waits for the busy flag to rise and fall. Next it produces sixteen serial clock pulses from a divided system clock and samples the data line on each falling clock edge. The last twelve sampled bits become the result. The four bits that come first must be zero, and the block raises an error flag when any of them is not.

The block enforces the converter's timing rules. The serial clock stays low whenever a conversion edge is made or the converter is busy. A guard interval separates the last read clock from the next conversion edge. A request that arrives while a frame is in progress is kept as a single pending start. If the busy flag does not fall in time, a timeout abandons the frame. A build-time option selects between two ways of driving the start line. In the normal variant the line idles high and a short low pulse starts each conversion. In the low-power variant the line idles low so the converter sleeps. A request raises the line for a wake-up interval, and its falling edge then starts the conversion. The line stays low through the conversion, so the converter returns to sleep afterwards.

All time intervals are parameters counted in system clock cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, adc_sclk is 0 and result_valid and timeout_err are 0. adc_conv_n is 1 in the normal variant (LOW_POWER=0) and 0 in the low-power variant (LOW_POWER=1).
- R2: In the normal variant, a start request in idle drives adc_conv_n low for exactly PULSE_CYC cycles, and the line then stays high while the conversion runs.
- R3: In the low-power variant, a start request raises adc_conv_n for exactly WAKE_CYC cycles. Its falling edge starts the conversion, and the line stays low through the conversion, the read and idle.
- R4: adc_sclk is 0 at every falling edge of adc_conv_n and during every cycle in which the converter's busy flag is high.
- R5: A read begins only after adc_busy has been seen high and then low. It consists of exactly 16 adc_sclk pulses, after which adc_sclk idles at 0.
- R6: adc_sdata is sampled on each falling edge of adc_sclk, first bit first. result holds the last 12 samples with the first of them as bit 11. result_valid is a single-cycle pulse issued after the 16th falling edge.
- R7: frame_err is 1 when any of the first 4 samples of the frame is 1, and 0 otherwise. It is updated together with result.
- R8: A falling edge of adc_conv_n that starts a conversion comes at least GUARD_CYC cycles after the last falling edge of adc_sclk.
- R9: Any number of start requests made while a frame is active, up to the end of its guard interval, cause exactly one further conversion. That conversion starts when the guard interval expires.
- R10: If the converter has not finished within TIMEOUT_CYC cycles of the start phase ending, timeout_err pulses for one cycle and the block returns to idle. In that case it produces no serial clock and no result_valid, and adc_conv_n returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request one conversion and read |
| adc_busy | input | 1 | Converter busy flag, high while converting |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_conv_n | output | 1 | Active-low conversion-start line |
| adc_sclk | output | 1 | Serial read clock |
| result | output | DATA_W | Last captured conversion result |
| result_valid | output | 1 | One-cycle strobe when result is updated |
| frame_err | output | 1 | Nonzero leading bits in the last frame |
| timeout_err | output | 1 | One-cycle strobe when a conversion timed out |

## Verification
The bench drives converter models whose conversion time varies at random. One directed word is all ones and one is all zeros. Others carry nonzero leading bits, which catches an off-by-one in the shift window or an inverted error flag. It repeats start requests during a read to show that a controller which queued every request, or dropped a pending one, would start the wrong number of conversions. It also measures the gap from the last read clock to the next start edge, which catches a guard interval that is too short. Finally, it holds busy high past the timeout to catch a block that would hang, or read garbage, instead of aborting. Both start-line variants are exercised, including the wake interval length and whether the line stays low for sleep.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WAKE    = 3'd1,
      ST_START   = 3'd2,
      ST_WAIT_HI = 3'd3,
      ST_WAIT_LO = 3'd4,
      ST_READ    = 3'd5,
      ST_GUARD   = 3'd6
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         count <= '0;
      end else if (count != CNT_TOP) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
   parameter int HALF_CYC = 5,
   parameter int NPULSE   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic fall_tick,
   output logic last_fall
);

   localparam int PC_W = $clog2(NPULSE + 1);

   logic            tick;
   logic [PC_W-1:0] pcnt;

   generate
      if (HALF_CYC == 1) begin : g_div_none
         assign tick = 1'b1;
      end else begin : g_div_count
         localparam int DIV_W = $clog2(HALF_CYC);
         localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_CYC - 1);
         logic [DIV_W-1:0] div;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               div <= '0;
            end else if (div == DIV_END) begin
               div <= '0;
            end else begin
               div <= div + 1'b1;
            end
         end
         assign tick = (div == DIV_END);
      end
   endgenerate

   assign fall_tick = run && tick && sclk;
   assign last_fall = fall_tick && (pcnt == PC_W'(NPULSE - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         sclk <= 1'b0;
         pcnt <= '0;
      end else if (tick) begin
         sclk <= ~sclk;
         if (sclk) begin
            pcnt <= pcnt + 1'b1;
         end
      end
   end

   // R5: never more pulses than one frame holds
   a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fall_tick |-> (pcnt < PC_W'(NPULSE)));

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
   parameter int DATA_W = 12,
   parameter int LEAD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              frame_end,
   input  logic              sdata,
   output logic [DATA_W-1:0] result,
   output logic              result_valid,
   output logic              frame_err
);

   localparam int FRAME_BITS = DATA_W + LEAD_W;

   logic [FRAME_BITS-1:0] shreg;
   logic [FRAME_BITS-1:0] word_now;

   assign word_now = {shreg[FRAME_BITS-2:0], sdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg        <= '0;
         result       <= '0;
         result_valid <= 1'b0;
         frame_err    <= 1'b0;
      end else begin
         result_valid <= sample && frame_end;
         if (sample) begin
            shreg <= word_now;
         end
         if (sample && frame_end) begin
            result    <= word_now[DATA_W-1:0];
            frame_err <= |word_now[FRAME_BITS-1:DATA_W];
         end
      end
   end

   // R6: the strobe lasts one cycle
   a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   // R6: result changes only together with the strobe
   a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> $stable(result));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int LEAD_W      = 4,
   parameter bit LOW_POWER   = 1'b0,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_CYC   = 4,
   parameter int SCLK_HALF   = 5,
   parameter int GUARD_CYC   = 38,
   parameter int WAKE_CYC    = 750,
   parameter int TIMEOUT_CYC = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              adc_busy,
   input  logic              adc_sdata,
   output logic              adc_conv_n,
   output logic              adc_sclk,
   output logic [DATA_W-1:0] result,
   output logic              result_valid,
   output logic              frame_err,
   output logic              timeout_err
);

   localparam int FRAME_BITS = DATA_W + LEAD_W;
   localparam int CNT_MAX    = max2(max2(PULSE_CYC, GUARD_CYC), max2(WAKE_CYC, TIMEOUT_CYC));
   localparam int CNT_W      = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] GUARD_END = CNT_W'(GUARD_CYC - 1);
   localparam logic [CNT_W-1:0] WAKE_END  = CNT_W'(WAKE_CYC - 1);
   localparam logic [CNT_W-1:0] TOUT_END  = CNT_W'(TIMEOUT_CYC - 1);
   localparam seq_state_t LAUNCH_ST  = LOW_POWER ? ST_WAKE : ST_START;
   localparam logic       CONV_IDLE  = LOW_POWER ? 1'b0 : 1'b1;

   initial begin : p_param_check
      if (DATA_W < 2)        $fatal(1, "DATA_W must be at least 2");
      if (LEAD_W < 1)        $fatal(1, "LEAD_W must be at least 1");
      if (SYNC_STAGES < 0)   $fatal(1, "SYNC_STAGES must not be negative");
      if (PULSE_CYC < 1)     $fatal(1, "PULSE_CYC must be at least 1");
      if (SCLK_HALF < 1)     $fatal(1, "SCLK_HALF must be at least 1");
      if (GUARD_CYC < 1)     $fatal(1, "GUARD_CYC must be at least 1");
      if (WAKE_CYC < 1)      $fatal(1, "WAKE_CYC must be at least 1");
      if (TIMEOUT_CYC < 2)   $fatal(1, "TIMEOUT_CYC must be at least 2");
   end

   seq_state_t       state_q, state_d;
   logic             pend_q, pend_d;
   logic             tout_d;
   logic             busy_s;
   logic             timer_clr;
   logic [CNT_W-1:0] tcnt;
   logic             sclk_run;
   logic             fall_tick;
   logic             last_fall;
   logic             conv_d;

   // busy flag synchronizer, depth chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_sync_none
         assign busy_s = adc_busy;
      end else if (SYNC_STAGES == 1) begin : g_sync_one
         logic busy_r;
         always_ff @(posedge clk) begin
            if (!rst_n) busy_r <= 1'b0;
            else        busy_r <= adc_busy;
         end
         assign busy_s = busy_r;
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], adc_busy};
         end
         assign busy_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   // sequencer
   always_comb begin
      state_d = state_q;
      pend_d  = pend_q || (start_req && (state_q != ST_IDLE));
      tout_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_req) begin
               state_d = LAUNCH_ST;
               pend_d  = 1'b0;
            end
         end
         ST_WAKE: begin
            if (tcnt == WAKE_END) state_d = ST_WAIT_HI;
         end
         ST_START: begin
            if (tcnt == PULSE_END) state_d = ST_WAIT_HI;
         end
         ST_WAIT_HI: begin
            if (busy_s) begin
               state_d = ST_WAIT_LO;
            end else if (tcnt == TOUT_END) begin
               state_d = ST_IDLE;
               tout_d  = 1'b1;
               pend_d  = 1'b0;
            end
         end
         ST_WAIT_LO: begin
            if (!busy_s) begin
               state_d = ST_READ;
            end else if (tcnt == TOUT_END) begin
               state_d = ST_IDLE;
               tout_d  = 1'b1;
               pend_d  = 1'b0;
            end
         end
         ST_READ: begin
            if (last_fall) state_d = ST_GUARD;
         end
         ST_GUARD: begin
            if (tcnt == GUARD_END) begin
               if (pend_d) begin
                  state_d = LAUNCH_ST;
                  pend_d  = 1'b0;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         default: begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
         end
      endcase
   end

   // the timeout window spans both wait states
   assign timer_clr = (state_d != state_q) &&
                      !((state_q == ST_WAIT_HI) && (state_d == ST_WAIT_LO));

   // start line level per variant
   generate
      if (LOW_POWER) begin : g_conv_sleep
         assign conv_d = (state_d == ST_WAKE);
      end else begin : g_conv_pulse
         assign conv_d = (state_d != ST_START);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_q      <= 1'b0;
         timeout_err <= 1'b0;
         adc_conv_n  <= CONV_IDLE;
      end else begin
         state_q     <= state_d;
         pend_q      <= pend_d;
         timeout_err <= tout_d;
         adc_conv_n  <= conv_d;
      end
   end

   assign sclk_run = (state_q == ST_READ);

   adc_cycle_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (timer_clr),
      .count (tcnt)
   );

   adc_sclk_gen #(
      .HALF_CYC (SCLK_HALF),
      .NPULSE   (FRAME_BITS)
   ) u_sclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (sclk_run),
      .sclk      (adc_sclk),
      .fall_tick (fall_tick),
      .last_fall (last_fall)
   );

   adc_rx_shift #(
      .DATA_W (DATA_W),
      .LEAD_W (LEAD_W)
   ) u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample       (fall_tick),
      .frame_end    (last_fall),
      .sdata        (adc_sdata),
      .result       (result),
      .result_valid (result_valid),
      .frame_err    (frame_err)
   );

   // checker: cycles since the last serial clock fall
   logic [CNT_W-1:0] gap_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_cnt <= '1;
      end else if (fall_tick) begin
         gap_cnt <= '0;
      end else if (gap_cnt != '1) begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

   // R8: start edge respects the guard interval
   a_r8_guard_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv_n) |-> ($past(gap_cnt) >= GUARD_END));

   // R4: clock low at the start edge
   a_r4_low_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv_n) |-> !adc_sclk);

   // R4: clock low while the converter is busy
   a_r4_low_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_s |-> !adc_sclk);

   // R5: clock idles low outside a read
   a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_READ) |-> !adc_sclk);

   // R10: an abort yields no result and restores the idle level
   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (!result_valid && (adc_conv_n == CONV_IDLE)));

   generate
      if (LOW_POWER) begin : g_sleep_chk
         // R3: start line held low while converting
         a_r3_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
            busy_s |-> !adc_conv_n);
      end
   endgenerate

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_conv_model (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        conv_n,
   input  logic        sclk,
   input  logic        stuck,
   input  logic        force_en,
   input  logic [15:0] force_word,
   output logic        busy,
   output logic        sdata,
   output logic [15:0] word_q
);
   logic pc, ps, run;
   int   t, len, fc;

   function automatic logic [15:0] make_word();
      logic [3:0]  lead;
      logic [11:0] data;
      lead = (($urandom % 4) == 0) ? 4'($urandom % 16) : 4'd0;
      data = 12'($urandom % 4096);
      return {lead, data};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pc <= conv_n; ps <= 1'b0; run <= 1'b0; busy <= 1'b0;
         t <= 0; len <= 100; fc <= 16; word_q <= 16'h0000;
      end else begin
         pc <= conv_n;
         ps <= sclk;
         if (ps && !sclk && fc < 16) fc <= fc + 1;
         if (pc && !conv_n) begin
            run <= 1'b1; t <= 0; fc <= 0;
            len <= 60 + int'($urandom % 1240);
         end else if (run) begin
            t <= t + 1;
            if (t == 2) busy <= 1'b1;
            if (t > 2 && t >= len && !stuck) begin
               busy   <= 1'b0;
               run    <= 1'b0;
               word_q <= force_en ? force_word : make_word();
            end
         end
      end
   end

   assign sdata = (fc < 16) ? word_q[15 - fc] : 1'b0;
endmodule

module adc_frame_mon #(
   parameter int GUARD_CYC = 38
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        conv_n,
   input  logic        sclk,
   input  logic        busy,
   input  logic        valid,
   input  logic        frame_err,
   input  logic [11:0] result,
   input  logic [15:0] word_q,
   output int          n_chk,
   output int          n_bad,
   output int          n_valid,
   output int          n_conv
);
   logic pc, ps, pb, pv, hi_seen, have_fall;
   int   cyc, falls, last_fall;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         pc = conv_n; ps = 0; pb = 0; pv = 0; hi_seen = 0; have_fall = 0;
         cyc = 0; falls = 0; last_fall = 0;
         n_chk = 0; n_bad = 0; n_valid = 0; n_conv = 0;
      end else begin
         cyc++;
         if (pc && !conv_n) begin
            n_conv++;
            falls = 0;
            if (have_fall) chk((cyc - last_fall) >= GUARD_CYC, "R8 guard gap", cyc - last_fall, GUARD_CYC);
         end
         if (ps && !sclk) begin
            falls++; last_fall = cyc; have_fall = 1;
         end
         if (busy && sclk) hi_seen = 1;
         if (pb && !busy) begin
            chk(!hi_seen, "R4 sclk during busy", int'(hi_seen), 0);
            hi_seen = 0;
         end
         if (valid) begin
            n_valid++;
            chk(!pv, "R6 strobe width", int'(pv), 0);
            chk(falls == 16, "R5 pulse count", falls, 16);
            chk(result == word_q[11:0], "R6 result", int'(result), int'(word_q[11:0]));
            chk(frame_err == (|word_q[15:12]), "R7 lead flag", int'(frame_err), int'(|word_q[15:12]));
         end
         pc = conv_n; ps = sclk; pb = busy; pv = valid;
      end
   end
endmodule

module adc_seq_ctrl_bench;
   localparam int PULSE = 4;
   localparam int HALF  = 5;
   localparam int GUARD = 38;
   localparam int WAKE  = 750;
   localparam int TOUT  = 2000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, start_a, start_b, stuck_a, force_a, force_b;
   logic [15:0] fword_a, fword_b;
   logic        busy_a, sdata_a, conv_a, sclk_a, valid_a, ferr_a, tout_a;
   logic        busy_b, sdata_b, conv_b, sclk_b, valid_b, ferr_b, tout_b;
   logic [11:0] res_a, res_b;
   logic [15:0] word_a, word_b;
   int          mc_a, mb_a, mv_a, mn_a, mc_b, mb_b, mv_b, mn_b;
   int          n_chk = 0, n_bad = 0;
   bit          reported = 0;

   adc_seq_ctrl #(.LOW_POWER(1'b0), .PULSE_CYC(PULSE), .SCLK_HALF(HALF),
      .GUARD_CYC(GUARD), .WAKE_CYC(WAKE), .TIMEOUT_CYC(TOUT)) u_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .start_req(start_a), .adc_busy(busy_a),
      .adc_sdata(sdata_a), .adc_conv_n(conv_a), .adc_sclk(sclk_a),
      .result(res_a), .result_valid(valid_a), .frame_err(ferr_a), .timeout_err(tout_a));

   adc_seq_ctrl #(.LOW_POWER(1'b1), .PULSE_CYC(PULSE), .SCLK_HALF(HALF),
      .GUARD_CYC(GUARD), .WAKE_CYC(WAKE), .TIMEOUT_CYC(TOUT)) u_adc_seq_ctrl_lp (
      .clk(clk), .rst_n(rst_n), .start_req(start_b), .adc_busy(busy_b),
      .adc_sdata(sdata_b), .adc_conv_n(conv_b), .adc_sclk(sclk_b),
      .result(res_b), .result_valid(valid_b), .frame_err(ferr_b), .timeout_err(tout_b));

   adc_conv_model u_model_a (.clk(clk), .rst_n(rst_n), .conv_n(conv_a), .sclk(sclk_a),
      .stuck(stuck_a), .force_en(force_a), .force_word(fword_a),
      .busy(busy_a), .sdata(sdata_a), .word_q(word_a));
   adc_conv_model u_model_b (.clk(clk), .rst_n(rst_n), .conv_n(conv_b), .sclk(sclk_b),
      .stuck(1'b0), .force_en(force_b), .force_word(fword_b),
      .busy(busy_b), .sdata(sdata_b), .word_q(word_b));

   adc_frame_mon #(.GUARD_CYC(GUARD)) u_mon_a (.clk(clk), .rst_n(rst_n), .conv_n(conv_a),
      .sclk(sclk_a), .busy(busy_a), .valid(valid_a), .frame_err(ferr_a), .result(res_a),
      .word_q(word_a), .n_chk(mc_a), .n_bad(mb_a), .n_valid(mv_a), .n_conv(mn_a));
   adc_frame_mon #(.GUARD_CYC(GUARD)) u_mon_b (.clk(clk), .rst_n(rst_n), .conv_n(conv_b),
      .sclk(sclk_b), .busy(busy_b), .valid(valid_b), .frame_err(ferr_b), .result(res_b),
      .word_q(word_b), .n_chk(mc_b), .n_bad(mb_b), .n_valid(mv_b), .n_conv(mn_b));

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  test done: total=%0d bad=%0d", n_chk + mc_a + mc_b, n_bad + mb_a + mb_b);
      end
   endtask

   task automatic wait_level(ref logic sig, input logic lvl, input int limit, output bit seen);
      seen = 0;
      for (int i = 0; i < limit; i++) begin
         if (sig == lvl) begin seen = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk) sig = 1'b1;
      @(negedge clk) sig = 1'b0;
   endtask

   task automatic frame_a();
      bit s; int w;
      pulse(start_a);
      wait_level(conv_a, 1'b0, 200, s);
      chk(s, "R2 start edge seen", int'(s), 1);
      w = 0;
      while (conv_a == 1'b0 && w < 1000) begin w++; @(negedge clk); end
      chk(w == PULSE, "R2 pulse width", w, PULSE);
      wait_level(busy_a, 1'b1, 50, s);
      wait_level(busy_a, 1'b0, 2000, s);
      chk(conv_a == 1'b1, "R2 line high at conversion end", int'(conv_a), 1);
      wait_level(valid_a, 1'b1, 600, s);
      chk(s, "R5 read completes", int'(s), 1);
      @(negedge clk);
   endtask

   task automatic frame_b();
      bit s; int w;
      chk(conv_b == 1'b0, "R3 idle low", int'(conv_b), 0);
      pulse(start_b);
      wait_level(conv_b, 1'b1, 50, s);
      w = 0;
      while (conv_b == 1'b1 && w < 5000) begin w++; @(negedge clk); end
      chk(w == WAKE, "R3 wake width", w, WAKE);
      wait_level(busy_b, 1'b1, 50, s);
      wait_level(busy_b, 1'b0, 2000, s);
      chk(conv_b == 1'b0, "R3 low at conversion end", int'(conv_b), 0);
      wait_level(valid_b, 1'b1, 600, s);
      chk(s, "R5 low-power read completes", int'(s), 1);
      repeat (3) @(negedge clk);
      chk(conv_b == 1'b0, "R3 stays low after read", int'(conv_b), 0);
   endtask

   initial begin : p_watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
   end

   initial begin : p_main
      bit s; int v0, c0, hold;
      void'($urandom(32'd2718));
      rst_n = 0; start_a = 0; start_b = 0; stuck_a = 0;
      force_a = 0; force_b = 0; fword_a = 0; fword_b = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(conv_a == 1'b1, "R1 normal line idle", int'(conv_a), 1);
      chk(conv_b == 1'b0, "R1 low-power line idle", int'(conv_b), 0);
      chk(sclk_a == 1'b0 && sclk_b == 1'b0, "R1 clock idle", int'(sclk_a | sclk_b), 0);
      chk(valid_a == 1'b0 && tout_a == 1'b0, "R1 strobes idle", int'(valid_a | tout_a), 0);

      // directed words: R6 extremes and R7 lead bits
      force_a = 1;
      fword_a = 16'h0FFF; frame_a();
      fword_a = 16'h0000; frame_a();
      fword_a = 16'h8ABC; frame_a();
      fword_a = 16'h1001; frame_a();
      fword_a = 16'h0800; frame_a();
      force_a = 0;

      // random frames
      for (int k = 0; k < 16; k++) frame_a();

      // R9 pending requests collapse into one
      v0 = mv_a; c0 = mn_a;
      pulse(start_a);
      wait_level(sclk_a, 1'b1, 3000, s);
      pulse(start_a);
      repeat (7) @(negedge clk);
      pulse(start_a);
      wait_level(valid_a, 1'b1, 600, s);
      @(negedge clk);
      pulse(start_a);
      repeat (4000) @(negedge clk);
      chk(mn_a - c0 == 2, "R9 conversions", mn_a - c0, 2);
      chk(mv_a - v0 == 2, "R9 results", mv_a - v0, 2);

      // R10 timeout
      v0 = mv_a; stuck_a = 1;
      pulse(start_a);
      hold = 0;
      while (!tout_a && hold < 5000) begin hold++; @(negedge clk); end
      chk(tout_a == 1'b1, "R10 timeout strobe", int'(tout_a), 1);
      chk(hold > TOUT, "R10 timeout not early", hold, TOUT);
      chk(valid_a == 1'b0, "R10 no strobe at abort", int'(valid_a), 0);
      @(negedge clk);
      chk(tout_a == 1'b0, "R10 strobe one cycle", int'(tout_a), 0);
      chk(conv_a == 1'b1, "R10 line idle after abort", int'(conv_a), 1);
      repeat (100) @(negedge clk);
      chk(sclk_a == 1'b0 && mv_a == v0, "R10 no read after abort", mv_a - v0, 0);
      stuck_a = 0;
      repeat (300) @(negedge clk);
      chk(mv_a == v0, "R10 late busy fall ignored", mv_a - v0, 0);
      frame_a();

      // low-power variant
      force_b = 1; fword_b = 16'h0FFF; frame_b();
      fword_b = 16'hF000; frame_b();
      force_b = 0;
      for (int k = 0; k < 4; k++) frame_b();
      chk(mv_b == 6, "R6 low-power results", mv_b, 6);

      report();
      $finish;
   end
endmodule